// File: doc/BRIEF.md
# Load-Use Interlock for an Eight-Stage Integer Pipeline

This block detects load-use hazards in an in-order integer pipeline with eight stages: fetch start, fetch finish, decode/register read, execute, first and second data-cache read, tag check, and writeback. The data cache is read across two stages, so load data is ready only when the second read stage has completed. The block compares the source registers of the instruction in the decode stage with the destinations of older instructions. If the youngest matching producer is a load that has not yet finished its second cache stage, the block raises a stall. The stall holds the decode and both fetch stages, and a bubble enters execute in its place.

The block keeps a small shadow of the back end. For each of the execute, first-cache, second-cache and tag-check stages it holds a valid bit, the destination register and a load flag. The block advances this shadow itself. When an instruction issues, the block registers into the execute stage two operand-select codes. Each code tells the execute-stage operand mux which pipeline latch supplies that operand. A dependent instruction therefore waits two, one or zero cycles, depending on how far it trails the load.

Top module: `load_use_interlock`

## Requirements
- R1: After reset, `stall` is 0, `ex_valid` is 0, and both forwarding selects are 0.
- R2: `stall` is combinational. It is 1 only when `rf_valid` is 1 and the youngest older valid producer of a source register is a load that sits in the execute stage or the first cache stage.
- R3: A consumer that directly follows a load stalls 2 cycles. A consumer two instructions behind the load stalls 1 cycle. A consumer three or more behind does not stall.
- R4: In the cycle after every stall cycle, `ex_valid` is 0 and both selects are 0.
- R5: Register 0 never matches. A load to register 0 followed by a use of register 0 neither stalls nor forwards.
- R6: Select encoding, valid while the instruction is in execute: 0 = register file, 1 = execute/first-cache latch, 2 = first/second-cache latch, 3 = second-cache/tag-check latch, 4 = tag-check/writeback latch.
- R7: A non-load producer 1, 2, 3 or 4 instructions ahead forwards with code 1, 2, 3 or 4 respectively, without a stall. At 5 or more instructions ahead the code is 0.
- R8: A load result is forwarded only with code 3 or 4, never 1 or 2. The code is 3 at distances 1 to 3 and 4 at distance 4.
- R9: When several older instructions write the same register, the youngest one decides both the stall and the select.
- R10: `stall` is never 1 for more than two consecutive cycles.
- R11: A cycle with `rf_valid` at 0 never stalls and puts a bubble (`ex_valid` 0) into execute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rf_valid | input | 1 | Decode stage holds a valid instruction |
| rf_src_a | input | RAW | First source register (0 = none) |
| rf_src_b | input | RAW | Second source register (0 = none) |
| rf_dst | input | RAW | Destination register (0 = none) |
| rf_load | input | 1 | Decode-stage instruction is a load |
| stall | output | 1 | Hold fetch and decode stages, insert bubble |
| ex_valid | output | 1 | Execute stage holds a real instruction |
| ex_fwd_a | output | 3 | Operand select for source A in execute |
| ex_fwd_b | output | 3 | Operand select for source B in execute |

## Verification
A stall and a forwarding decision can both apply to one instruction. Take a consumer two places behind a load that also reads the result of the ALU operation between them. It must wait exactly one cycle. It must then leave with source A taken from the second-cache/tag-check latch and source B from the first/second-cache latch. The bench issues that sequence and counts the stall cycles at the ports. It checks that each of those cycles left a bubble. It then compares both select codes in the issuing cycle with values derived from the stage distances.

// File: rtl/load_use_interlock.sv
module load_use_interlock #(
  parameter int RAW = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           rf_valid,
  input  logic [RAW-1:0] rf_src_a,
  input  logic [RAW-1:0] rf_src_b,
  input  logic [RAW-1:0] rf_dst,
  input  logic           rf_load,
  output logic           stall,
  output logic           ex_valid,
  output logic [2:0]     ex_fwd_a,
  output logic [2:0]     ex_fwd_b
);

  localparam logic [2:0] SEL_RF = 3'd0;
  localparam logic [2:0] SEL_DF = 3'd1;
  localparam logic [2:0] SEL_DS = 3'd2;
  localparam logic [2:0] SEL_TC = 3'd3;
  localparam logic [2:0] SEL_WB = 3'd4;

  logic           ex_w, df_w, ds_w, tc_w;
  logic           ex_ld, df_ld, ds_ld;
  logic [RAW-1:0] ex_rd, df_rd, ds_rd, tc_rd;

  function automatic logic [2:0] pick(input logic [RAW-1:0] s);
    if (s == '0)                   return SEL_RF;
    else if (ex_w && ex_rd == s)   return SEL_DF;
    else if (df_w && df_rd == s)   return SEL_DS;
    else if (ds_w && ds_rd == s)   return SEL_TC;
    else if (tc_w && tc_rd == s)   return SEL_WB;
    else                           return SEL_RF;
  endfunction

  logic [2:0] sel_a, sel_b;
  logic       haz_a, haz_b, issue;

  assign sel_a = pick(rf_src_a);
  assign sel_b = pick(rf_src_b);
  assign haz_a = (sel_a == SEL_DF && ex_ld) || (sel_a == SEL_DS && df_ld);
  assign haz_b = (sel_b == SEL_DF && ex_ld) || (sel_b == SEL_DS && df_ld);
  assign stall = rf_valid && (haz_a || haz_b);
  assign issue = rf_valid && !stall;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ex_valid <= 1'b0;
      ex_fwd_a <= SEL_RF;
      ex_fwd_b <= SEL_RF;
      ex_w  <= 1'b0; df_w  <= 1'b0; ds_w <= 1'b0; tc_w <= 1'b0;
      ex_ld <= 1'b0; df_ld <= 1'b0; ds_ld <= 1'b0;
      ex_rd <= '0;   df_rd <= '0;   ds_rd <= '0;   tc_rd <= '0;
    end else begin
      ex_valid <= issue;
      ex_fwd_a <= issue ? sel_a : SEL_RF;
      ex_fwd_b <= issue ? sel_b : SEL_RF;
      ex_w  <= issue && (rf_dst != '0);
      ex_ld <= issue && rf_load;
      ex_rd <= rf_dst;
      df_w  <= ex_w;  df_ld <= ex_ld; df_rd <= ex_rd;
      ds_w  <= df_w;  ds_ld <= df_ld; ds_rd <= df_rd;
      tc_w  <= ds_w;                  tc_rd <= ds_rd;
    end
  end

  a_r2_stall_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> rf_valid);

  a_r4_bubble_after_stall: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (!ex_valid && ex_fwd_a == SEL_RF && ex_fwd_b == SEL_RF));

  a_r10_stall_at_most_two: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && $past(stall)) |=> !stall);

  a_r11_idle_gives_bubble: assert property (@(posedge clk) disable iff (!rst_n)
    !rf_valid |=> !ex_valid);

  a_r8_no_load_from_df: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_valid && (ex_fwd_a == SEL_DF || ex_fwd_b == SEL_DF)) |-> !df_ld);

  a_r8_no_load_from_ds: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_valid && (ex_fwd_a == SEL_DS || ex_fwd_b == SEL_DS)) |-> !ds_ld);

endmodule

// File: tb/test_load_use_interlock.sv
`timescale 1ns/1ps
module test_load_use_interlock;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rf_valid = 1'b0;
  logic [4:0] rf_src_a = '0, rf_src_b = '0, rf_dst = '0;
  logic       rf_load = 1'b0;
  logic       stall, ex_valid;
  logic [2:0] ex_fwd_a, ex_fwd_b;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  load_use_interlock #(.RAW(5)) i_load_use_interlock (
    .clk(clk), .rst_n(rst_n), .rf_valid(rf_valid), .rf_src_a(rf_src_a),
    .rf_src_b(rf_src_b), .rf_dst(rf_dst), .rf_load(rf_load),
    .stall(stall), .ex_valid(ex_valid), .ex_fwd_a(ex_fwd_a), .ex_fwd_b(ex_fwd_b));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic flush(input int n);
    rf_valid = 0; rf_src_a = 0; rf_src_b = 0; rf_dst = 0; rf_load = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic op(input logic [4:0] a, input logic [4:0] b, input logic [4:0] d,
                    input logic l, input int es, input int efa, input int efb,
                    input string tag);
    int n = 0;
    rf_valid = 1; rf_src_a = a; rf_src_b = b; rf_dst = d; rf_load = l;
    #1;
    while (stall && n < 8) begin
      n++;
      @(negedge clk);
      chk({tag, " R4 bubble valid"}, ex_valid, 0);
      #1;
    end
    chk({tag, " stall cycles"}, n, es);
    @(negedge clk);
    rf_valid = 0;
    chk({tag, " ex_valid"}, ex_valid, 1);
    chk({tag, " fwd_a"}, ex_fwd_a, efa);
    chk({tag, " fwd_b"}, ex_fwd_b, efb);
  endtask

  task automatic t_reset;
    chk("R1 stall", stall, 0);
    chk("R1 ex_valid", ex_valid, 0);
    chk("R1 fwd_a", ex_fwd_a, 0);
    chk("R1 fwd_b", ex_fwd_b, 0);
  endtask

  task automatic t_load_dist(input int k, input int es, input int ef);
    op(0, 0, 5, 1, 0, 0, 0, "R3 load");
    for (int i = 1; i < k; i++) op(0, 0, 0, 0, 0, 0, 0, "R3 filler");
    op(5, 0, 0, 0, es, ef, 0, $sformatf("R3 R8 R10 load distance %0d", k));
    flush(6);
  endtask

  task automatic t_alu_dist(input int k, input int ef);
    op(0, 0, 7, 0, 0, 0, 0, "R7 alu");
    for (int i = 1; i < k; i++) op(0, 0, 0, 0, 0, 0, 0, "R7 filler");
    op(0, 7, 0, 0, 0, 0, ef, $sformatf("R7 R6 alu distance %0d", k));
    flush(6);
  endtask

  task automatic t_zero;
    op(0, 0, 0, 1, 0, 0, 0, "R5 load r0");
    op(0, 0, 0, 0, 0, 0, 0, "R5 use r0");
    flush(6);
  endtask

  task automatic t_youngest;
    op(0, 0, 5, 1, 0, 0, 0, "R9 older load");
    op(0, 0, 5, 0, 0, 0, 0, "R9 younger alu");
    op(5, 0, 0, 0, 0, 1, 0, "R9 alu wins");
    flush(6);
    op(0, 0, 6, 0, 0, 0, 0, "R9 older alu");
    op(0, 0, 6, 1, 0, 0, 0, "R9 younger load");
    op(6, 0, 0, 0, 2, 3, 0, "R9 load wins");
    flush(6);
  endtask

  task automatic t_mixed;
    op(0, 0, 3, 1, 0, 0, 0, "R2 load r3");
    op(0, 0, 4, 0, 0, 0, 0, "R2 alu r4");
    op(3, 4, 0, 0, 1, 3, 2, "R2 R6 stall plus forward");
    flush(6);
  endtask

  task automatic t_invalid;
    op(0, 0, 9, 1, 0, 0, 0, "R11 load r9");
    rf_valid = 0; rf_src_a = 9;
    #1;
    chk("R2 R11 invalid no stall", stall, 0);
    @(negedge clk);
    chk("R11 bubble ex_valid", ex_valid, 0);
    chk("R11 bubble fwd_a", ex_fwd_a, 0);
    flush(6);
  endtask

  task automatic t_double;
    op(0, 0, 5, 1, 0, 0, 0, "R3 load");
    op(5, 0, 0, 0, 2, 3, 0, "R3 first use");
    op(0, 5, 0, 0, 0, 0, 4, "R3 R8 second use");
    flush(6);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_load_dist(1, 2, 3);
    t_load_dist(2, 1, 3);
    t_load_dist(3, 0, 3);
    t_load_dist(4, 0, 4);
    t_load_dist(5, 0, 0);
    for (int k = 1; k <= 5; k++) t_alu_dist(k, (k <= 4) ? k : 0);
    t_zero();
    t_youngest();
    t_mixed();
    t_invalid();
    t_double();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule